// File: doc/BRIEF.md
# Floating-Point Status Register Field Writer

This block owns the 32-bit floating-point status and control register and carries out the instruction that writes selected 4-bit fields of that register from a floating-point source operand. Each cycle it may receive a 32-bit instruction word with a valid strobe and a 64-bit source operand. It checks that the word is the field-write instruction. It then turns the instruction's 8-bit field-select mask into a 32-bit nibble mask and merges the chosen nibbles of the source's low word into the register on the next rising clock edge.

When the instruction's record bit is set, the block also hands the new top status nibble to the condition-register file as a write of condition field 1, in the same cycle as the instruction. A valid word that is not this instruction raises an illegal-opcode flag for that cycle and changes nothing.

Top module: `fsc_field_mover`

## Requirements
- R1: A synchronous active-high reset clears `status_q` to 0x00000000. This value means round-to-nearest with no exception bits set.
- R2: With `instr_valid` high, the word is accepted only when `instr_word[31:26]` equals 63 and `instr_word[10:1]` equals 711. The base encoding is 0xFC00058E.
- R3: The 8-bit field mask is `instr_word[24:17]`. Mask bit `instr_word[17+n]` selects nibble `status_q[4n+3:4n]`, so `instr_word[24]` selects bits 31:28 and `instr_word[17]` selects bits 3:0 (the rounding-mode nibble). On an accepted word, each selected nibble takes the same nibble of `src_operand[31:0]` at the next rising edge.
- R4: Nibbles whose mask bit is clear keep their old value, so the new value is (old & ~mask) | (src & mask).
- R5: `src_operand[63:32]` has no effect on the register or on the outputs.
- R6: When an accepted word has `instr_word[0]` (record bit) set, `cr1_we` is 1 in that same cycle and `cr1_data` equals bits 31:28 of the value the register takes at the next edge.
- R7: When the record bit is 0, or no word is accepted, `cr1_we` is 0 and `cr1_data` is 0.
- R8: `instr_word[25]` and `instr_word[16]` are ignored. The result is the same as with both bits at 0.
- R9: With `instr_valid` high and the opcode check failing, `illegal` is 1 in that cycle, the register keeps its value and `cr1_we` stays 0. Otherwise `illegal` is 0.
- R10: With `instr_valid` low, the register keeps its value and `cr1_we` and `illegal` are 0.
- R11: A mask of 0x00 leaves the register unchanged, but the record still happens when the record bit is set. A mask of 0xFF copies the whole of `src_operand[31:0]`.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word valid this cycle |
| instr_word | input | 32 | Instruction word |
| src_operand | input | 64 | Floating-point source operand; only the low 32 bits are used |
| status_q | output | 32 | Current status and control register value |
| cr1_we | output | 1 | Write enable for condition field 1 |
| cr1_data | output | 4 | New top status nibble for condition field 1 |
| illegal | output | 1 | Valid word whose opcode did not match |

## Verification
The assertions assume that `instr_valid`, `instr_word` and `src_operand` are settled and free of X before each rising edge. They also assume that a word is presented for exactly one cycle, so that each cycle is one instruction. The bench changes all inputs only on falling edges. It applies exactly one instruction or idle slot per cycle and never leaves an input undriven after reset. Opcodes near the accepted value are made by altering single fields of the base encoding, so the checks stay within fully defined words.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
    localparam int WORD_W     = 32;
    localparam int SRC_W      = 64;
    localparam int FIELD_W    = 4;
    localparam int NUM_FIELDS = 8;
    localparam int CR_W       = 4;
    localparam int PRIM_W     = 6;
    localparam int EXT_W      = 10;

    localparam logic [PRIM_W-1:0] PRIMARY_OP = 6'd63;
    localparam logic [EXT_W-1:0]  EXT_OP     = 10'd711;

    // Instruction layout, most significant bit first
    typedef struct packed {
        logic [PRIM_W-1:0]     primary;
        logic                  len_sel;
        logic [NUM_FIELDS-1:0] fmask;
        logic                  width_sel;
        logic [4:0]            src_idx;
        logic [EXT_W-1:0]      ext;
        logic                  record;
    } fmove_instr_t;

    typedef struct packed {
        logic                  write_en;
        logic                  record_en;
        logic                  illegal;
        logic [NUM_FIELDS-1:0] fmask;
    } fmove_ctl_t;

    function automatic fmove_instr_t split_word(input logic [WORD_W-1:0] w);
        return fmove_instr_t'(w);
    endfunction

    function automatic logic opcode_hit(input fmove_instr_t i);
        return (i.primary == PRIMARY_OP) && (i.ext == EXT_OP);
    endfunction
endpackage

// File: rtl/fsc_decode.sv
module fsc_decode
    import fsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [WORD_W-1:0] word,
    output fmove_ctl_t        ctl
);
    fmove_instr_t fields;
    logic         hit;
    logic         unused_fields;

    assign fields = split_word(word);
    assign hit    = opcode_hit(fields);
    // width/length selectors and register index play no part here
    assign unused_fields = ^{fields.len_sel, fields.width_sel, fields.src_idx};

    always_comb begin
        ctl.write_en  = valid && hit;
        ctl.record_en = valid && hit && fields.record;
        ctl.illegal   = valid && !hit;
        ctl.fmask     = fields.fmask;
    end

    p_single_outcome_r9: assert property (@(posedge clk) disable iff (rst)
        !(ctl.write_en && ctl.illegal));
    p_record_needs_write_r7: assert property (@(posedge clk) disable iff (rst)
        ctl.record_en |-> ctl.write_en);
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !valid |-> !(ctl.write_en || ctl.illegal));
endmodule

// File: rtl/fsc_mask_expand.sv
module fsc_mask_expand #(
    parameter int NUM_FIELDS = 8,
    parameter int FIELD_W    = 4,
    localparam int MASK_W    = NUM_FIELDS * FIELD_W
) (
    input  logic [NUM_FIELDS-1:0] fmask,
    output logic [MASK_W-1:0]     nib_mask
);
    for (genvar n = 0; n < NUM_FIELDS; n++) begin : g_field
        assign nib_mask[n*FIELD_W +: FIELD_W] = {FIELD_W{fmask[n]}};
    end

    always_comb begin
        p_mask_width_r3: assert ($countones(nib_mask) == FIELD_W * $countones(fmask));
    end
endmodule

// File: rtl/fsc_status_reg.sv
module fsc_status_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             write_en,
    input  logic [WIDTH-1:0] mask,
    input  logic [WIDTH-1:0] src_lo,
    output logic [WIDTH-1:0] merged,
    output logic [WIDTH-1:0] q
);
    assign merged = (q & ~mask) | (src_lo & mask);

    always_ff @(posedge clk) begin
        if (rst)           q <= '0;
        else if (write_en) q <= merged;
    end

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !write_en |=> $stable(q));
    p_keep_clear_r4: assert property (@(posedge clk) disable iff (rst)
        write_en |=> ((q ^ $past(q)) & ~$past(mask)) == '0);
    p_load_set_r3: assert property (@(posedge clk) disable iff (rst)
        write_en |=> ((q ^ $past(src_lo)) & $past(mask)) == '0);
endmodule

// File: rtl/fsc_field_mover.sv
module fsc_field_mover
    import fsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [WORD_W-1:0] instr_word,
    input  logic [SRC_W-1:0]  src_operand,
    output logic [WORD_W-1:0] status_q,
    output logic              cr1_we,
    output logic [CR_W-1:0]   cr1_data,
    output logic              illegal
);
    localparam int MASK_W = NUM_FIELDS * FIELD_W;

    fmove_ctl_t        ctl;
    logic [MASK_W-1:0] nib_mask;
    logic [WORD_W-1:0] merged;
    logic              unused_src_hi;

    assign unused_src_hi = ^src_operand[SRC_W-1:WORD_W];

    fsc_decode u_decode (
        .clk   (clk),
        .rst   (rst),
        .valid (instr_valid),
        .word  (instr_word),
        .ctl   (ctl)
    );

    fsc_mask_expand #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_expand (
        .fmask    (ctl.fmask),
        .nib_mask (nib_mask)
    );

    fsc_status_reg #(.WIDTH(WORD_W)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .write_en (ctl.write_en),
        .mask     (nib_mask),
        .src_lo   (src_operand[WORD_W-1:0]),
        .merged   (merged),
        .q        (status_q)
    );

    assign cr1_we   = ctl.record_en;
    assign cr1_data = ctl.record_en ? merged[WORD_W-1 -: CR_W] : '0;
    assign illegal  = ctl.illegal;

    p_cr1_follows_r6: assert property (@(posedge clk) disable iff (rst)
        cr1_we |=> status_q[WORD_W-1 -: CR_W] == $past(cr1_data));
    p_illegal_no_record_r9: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !cr1_we);
    p_illegal_holds_r9: assert property (@(posedge clk) disable iff (rst)
        illegal |=> $stable(status_q));
endmodule

// File: tb/sim_fsc_field_mover.sv
module sim_fsc_field_mover;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic [63:0] src_operand = '0;
    logic [31:0] status_q;
    logic        cr1_we;
    logic [3:0]  cr1_data;
    logic        illegal;

    always #10 clk = ~clk;   // 50 MHz

    fsc_field_mover u0 (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .src_operand(src_operand), .status_q(status_q), .cr1_we(cr1_we),
        .cr1_data(cr1_data), .illegal(illegal)
    );

    typedef struct {
        logic [31:0] st;
        logic        we;
        logic [3:0]  cd;
        logic        ill;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          failures = 0;
    logic [31:0] model_q = '0;
    bit          driver_done = 0;

    function automatic logic [31:0] enc(input logic [7:0] fm, input logic rc);
        return 32'hFC00058E | ({24'd0, fm} << 17) | {31'd0, rc};
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // driver: applies one slot per cycle and queues the expectation
    task automatic drive(input logic v, input logic [31:0] w, input logic [63:0] s, input string tag);
        exp_t e;
        logic hit, wr;
        logic [31:0] m, nq;
        @(negedge clk);
        instr_valid = v; instr_word = w; src_operand = s;
        hit = (w[31:26] == 6'd63) && (w[10:1] == 10'd711);
        wr  = v && hit;
        m = '0;
        for (int k = 0; k < 8; k++) if (w[17+k]) m[4*k +: 4] = 4'hF;
        nq = wr ? ((model_q & ~m) | (s[31:0] & m)) : model_q;
        e.st  = nq;
        e.we  = wr && w[0];
        e.cd  = (wr && w[0]) ? nq[31:28] : 4'h0;
        e.ill = v && !hit;
        e.tag = tag;
        model_q = nq;
        sb.push_back(e);
    endtask

    // monitor: combinational outputs before the edge, register after it
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, "cr1_we", {31'd0, cr1_we}, {31'd0, e.we});
                check(e.tag, "cr1_data", {28'd0, cr1_data}, {28'd0, e.cd});
                check(e.tag, "illegal", {31'd0, illegal}, {31'd0, e.ill});
                @(posedge clk);
                #5;
                check(e.tag, "status_q", status_q, e.st);
            end
        end
    end

    initial begin
        logic [31:0] lf;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "reset status_q", status_q, 32'h0);
        check("R1", "reset cr1_we", {31'd0, cr1_we}, 32'd0);

        drive(1, enc(8'h01, 0), 64'h0000_0000_0000_0003, "R3 rounding nibble");
        drive(1, enc(8'h80, 1), 64'h1234_5678_9ABC_DEF0, "R6 top nibble record");
        drive(1, enc(8'h80, 0), 64'h0000_0000_5000_0000, "R7 no record");
        drive(1, enc(8'hAA, 1), 64'h0000_0000_FFFF_FFFF, "R4 alternating mask");
        drive(1, enc(8'hFF, 0), 64'hDEAD_BEEF_CAFE_F00D, "R11 full copy");
        drive(1, enc(8'h00, 1), 64'h0000_0000_0000_0000, "R11 empty mask record");
        drive(1, enc(8'h3C, 0), 64'hFFFF_FFFF_0000_0000, "R5 high word ignored");
        drive(1, enc(8'hC3, 1) | 32'h0201_0000, 64'h0000_0000_8765_4321, "R8 L and W ignored");
        drive(1, enc(8'hFF, 1) ^ 32'h0400_0000, 64'h0000_0000_0000_0000, "R9 bad primary");
        drive(1, enc(8'hFF, 1) ^ 32'h0000_0010, 64'h0000_0000_0000_0000, "R9 bad extended");
        drive(1, enc(8'hFF, 1) ^ 32'h0000_0002, 64'h0000_0000_0000_0000, "R2 extended bit 1");
        drive(0, enc(8'hFF, 1), 64'h0000_0000_0000_0000, "R10 not valid");
        drive(1, 32'hFC00058E, 64'h0000_0000_FFFF_FFFF, "R2 base encoding");
        lf = 32'hACE1_2357;
        for (int i = 0; i < 200; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            drive(1, enc(lf[7:0], lf[8]) | (lf & 32'h0201_F800),
                  {~lf, lf ^ 32'h5A5A_A5A5}, "R3 mixed masks");
        end
        drive(0, 32'h0, 64'h0, "R10 drain");
        repeat (3) @(posedge clk);
        driver_done = 1;
    end

    initial begin
        fork
            wait (driver_done == 1);
            begin
                repeat (5000) @(posedge clk);
                failures++;
                $display("FAIL watchdog timeout actual=running expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule